// File: doc/BRIEF.md
# Power-Gating Wake Sequencer

This block sequences a switchable power domain into and out of a deep low-power state. A sleep request, accepted only while power-off is enabled, removes the domain's supply through an external control output. In the same step it asserts reset on the gated logic. A minimum off-time, set in coarse units, then has to elapse before the supply may return. This keeps the external regulator from cycling too fast.

A wake event is honoured only when its next-state code selects full-on operation. A wake that arrives during the off-time is remembered and carried out the moment that time expires. After the supply is restored, the block waits for a power-good indication. It then holds reset for a second programmed duration before releasing the domain. Both durations run from one shared prescaler that gives a tick every PRESCALE clock cycles. A count value of N lasts exactly N+1 ticks.

When power-good is tied high, the reset hold alone has to cover the supply ramp and any clock relock time. Software must therefore size the reset count for that case.

Top module: `power_gate_seq`

## Requirements
- R1: After synchronous reset, `supply_on` is 1, `dom_rst` is 0 and `seq_busy` is 0.
- R2: In the full-on state, a sleep request with `pwr_off_en` = 1 makes `supply_on` 0 and `dom_rst` 1 from the next clock cycle.
- R3: With a full-on wake already pending, the supply stays off for exactly (`off_count`+1)·PRESCALE cycles after the sleep request is taken. A count of 0 gives one prescaler period.
- R4: A wake event with `wake_code` = 2'b00 that arrives while the off-time is still running is not lost. It is acted on in the cycle the off-time expires.
- R5: A wake event with any `wake_code` other than 2'b00 is ignored, and the supply stays off.
- R6: Once the off-time has expired with no wake pending, the supply stays off until a wake with code 2'b00 is sampled. `supply_on` is then 1 from the next cycle.
- R7: While the supply is restored and power-good has not yet been sampled high, `dom_rst` stays 1 and `seq_busy` is 1.
- R8: `dom_rst` falls exactly (R+1)·PRESCALE cycles after the first clock edge at which `pwr_good` is sampled high in the wake sequence. R is the latched reset count. `seq_busy` is 0 afterwards.
- R9: The reset count is captured in the cycle the sleep request is taken. Later changes to `rst_count` have no effect on that sequence.
- R10: With `pwr_off_en` = 0, a sleep request is ignored: the supply stays on and `dom_rst` stays 0.
- R11: Whenever `supply_on` is 0, `dom_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter the low-power state |
| wake_evt | input | 1 | Wake event strobe |
| wake_code | input | 2 | Requested next state; 2'b00 means full-on |
| pwr_off_en | input | 1 | Enables supply removal and the timed sequence |
| off_count | input | CNT_W (12) | Minimum off-time in prescaler ticks, minus one |
| rst_count | input | CNT_W (12) | Reset hold after power-good in ticks, minus one |
| pwr_good | input | 1 | Supply is stable |
| supply_on | output | 1 | External supply enable (1 = powered) |
| dom_rst | output | 1 | Reset to the gated domain (1 = asserted) |
| seq_busy | output | 1 | Wake sequence running (supply back, reset still held) |

## Verification
A control state that is wrong shows up at the ports immediately, because each of the three outputs decodes the state register directly. A lost pending wake shows up differently: the supply stays off past the expected off-time, and this is visible within one prescaler tick of the expiry. An off-by-one in the prescaler or in either countdown moves the edge of `supply_on` or of `dom_rst` by at least one cycle. A latched reset count that follows the live input shifts the release by whole prescaler periods. Either error is therefore caught by counting cycles between the port edges.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [2:0] {
        ST_ON       = 3'd0,
        ST_OFF_WAIT = 3'd1,
        ST_OFF_IDLE = 3'd2,
        ST_RAMP     = 3'd3,
        ST_RST_HOLD = 3'd4
    } pgw_state_e;

    localparam logic [1:0] NEXT_FULL_ON = 2'b00;

    localparam int N_PHASE = 2;
    localparam int PH_OFF  = 0;
    localparam int PH_RST  = 1;

    function automatic logic wake_accept(input logic evt, input logic [1:0] code);
        return evt && (code == NEXT_FULL_ON);
    endfunction

    function automatic logic supply_removed(input pgw_state_e s);
        return (s == ST_OFF_WAIT) || (s == ST_OFF_IDLE);
    endfunction

    function automatic logic in_wake_seq(input pgw_state_e s);
        return (s == ST_RAMP) || (s == ST_RST_HOLD);
    endfunction

endpackage

// File: rtl/pgw_prescaler.sv
module pgw_prescaler #(
    parameter int PRESCALE = 32000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/pgw_countdown.sv
module pgw_countdown #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run && tick && (cnt_q == '0);
endmodule

// File: rtl/pgw_fsm.sv
module pgw_fsm
    import pgw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_req,
    input  logic               wake_ok,
    input  logic               pwr_off_en,
    input  logic               pwr_good,
    input  logic [N_PHASE-1:0] ph_exp,
    output pgw_state_e         state,
    output logic [N_PHASE-1:0] ph_load,
    output logic [N_PHASE-1:0] ph_run,
    output logic               pre_clr,
    output logic               capture_rcnt
);
    pgw_state_e state_q, state_d;
    logic       pend_q, pend_d;

    always_comb begin
        state_d      = state_q;
        pend_d       = pend_q;
        ph_load      = '0;
        pre_clr      = 1'b0;
        capture_rcnt = 1'b0;
        unique case (state_q)
            ST_ON: begin
                if (sleep_req && pwr_off_en) begin
                    state_d         = ST_OFF_WAIT;
                    ph_load[PH_OFF] = 1'b1;
                    pre_clr         = 1'b1;
                    capture_rcnt    = 1'b1;
                    pend_d          = 1'b0;
                end
            end
            ST_OFF_WAIT: begin
                if (ph_exp[PH_OFF]) begin
                    state_d = (pend_q || wake_ok) ? ST_RAMP : ST_OFF_IDLE;
                    pend_d  = 1'b0;
                end else if (wake_ok) begin
                    pend_d = 1'b1;
                end
            end
            ST_OFF_IDLE: begin
                if (wake_ok) begin
                    state_d = ST_RAMP;
                end
            end
            ST_RAMP: begin
                if (pwr_good) begin
                    state_d         = ST_RST_HOLD;
                    ph_load[PH_RST] = 1'b1;
                    pre_clr         = 1'b1;
                end
            end
            ST_RST_HOLD: begin
                if (ph_exp[PH_RST]) begin
                    state_d = ST_ON;
                end
            end
            default: state_d = ST_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ON;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        ph_run         = '0;
        ph_run[PH_OFF] = (state_q == ST_OFF_WAIT);
        ph_run[PH_RST] = (state_q == ST_RST_HOLD);
    end

    assign state = state_q;
endmodule

// File: rtl/power_gate_seq.sv
module power_gate_seq
    import pgw_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int PRESCALE = 32000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             wake_evt,
    input  logic [1:0]       wake_code,
    input  logic             pwr_off_en,
    input  logic [CNT_W-1:0] off_count,
    input  logic [CNT_W-1:0] rst_count,
    input  logic             pwr_good,
    output logic             supply_on,
    output logic             dom_rst,
    output logic             seq_busy
);
    pgw_state_e         state;
    logic [N_PHASE-1:0] ph_load;
    logic [N_PHASE-1:0] ph_run;
    logic [N_PHASE-1:0] ph_exp;
    logic [CNT_W-1:0]   ph_val [N_PHASE];
    logic               pre_clr;
    logic               capture_rcnt;
    logic               tick;
    logic [CNT_W-1:0]   rcnt_q;

    pgw_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sleep_req    (sleep_req),
        .wake_ok      (wake_accept(wake_evt, wake_code)),
        .pwr_off_en   (pwr_off_en),
        .pwr_good     (pwr_good),
        .ph_exp       (ph_exp),
        .state        (state),
        .ph_load      (ph_load),
        .ph_run       (ph_run),
        .pre_clr      (pre_clr),
        .capture_rcnt (capture_rcnt)
    );

    pgw_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (pre_clr),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt_q <= '0;
        end else if (capture_rcnt) begin
            rcnt_q <= rst_count;
        end
    end

    assign ph_val[PH_OFF] = off_count;
    assign ph_val[PH_RST] = rcnt_q;

    for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
        pgw_countdown #(.W(CNT_W)) u_cd (
            .clk      (clk),
            .rst      (rst),
            .load     (ph_load[g]),
            .load_val (ph_val[g]),
            .run      (ph_run[g]),
            .tick     (tick),
            .expired  (ph_exp[g])
        );
    end

    assign supply_on = !supply_removed(state);
    assign dom_rst   = (state != ST_ON);
    assign seq_busy  = in_wake_seq(state);
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int PRESCALE = 32000
) (
    input logic clk,
    input logic rst,
    input logic sleep_req,
    input logic pwr_off_en,
    input logic supply_on,
    input logic dom_rst,
    input logic seq_busy
);
    logic [31:0] off_run;
    logic [31:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_run  <= '0;
            busy_run <= '0;
        end else begin
            if (supply_on)               off_run <= '0;
            else if (off_run != '1)      off_run <= off_run + 1'b1;
            if (!seq_busy)               busy_run <= '0;
            else if (busy_run != '1)     busy_run <= busy_run + 1'b1;
        end
    end

    p_off_implies_reset_r11: assert property (@(posedge clk) disable iff (rst)
        !supply_on |-> dom_rst);

    p_sleep_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (!dom_rst && sleep_req && pwr_off_en) |=> (!supply_on && dom_rst));

    p_disabled_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!dom_rst && !pwr_off_en) |=> (!dom_rst && supply_on));

    p_min_off_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(supply_on) |-> (off_run >= 32'(PRESCALE)));

    p_busy_powered_r7: assert property (@(posedge clk) disable iff (rst)
        seq_busy |-> (supply_on && dom_rst));

    p_release_hold_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(dom_rst) |-> ($past(seq_busy) && busy_run >= 32'(PRESCALE)));
endmodule

bind power_gate_seq pgw_checker #(.PRESCALE(PRESCALE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep_req  (sleep_req),
    .pwr_off_en (pwr_off_en),
    .supply_on  (supply_on),
    .dom_rst    (dom_rst),
    .seq_busy   (seq_busy)
);

// File: tb/power_gate_seq_tb.sv
module power_gate_seq_tb;
    localparam int P  = 4;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_req = 1'b0;
    logic          wake_evt = 1'b0;
    logic [1:0]    wake_code = 2'b00;
    logic          pwr_off_en = 1'b0;
    logic [CW-1:0] off_count = '0;
    logic [CW-1:0] rst_count = '0;
    logic          pwr_good = 1'b0;
    logic          supply_on, dom_rst, seq_busy;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    power_gate_seq #(.CNT_W(CW), .PRESCALE(P)) u_dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_evt(wake_evt),
        .wake_code(wake_code), .pwr_off_en(pwr_off_en), .off_count(off_count),
        .rst_count(rst_count), .pwr_good(pwr_good), .supply_on(supply_on),
        .dom_rst(dom_rst), .seq_busy(seq_busy)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input int n, input int r, input bit early, input bit tied);
        int t;
        int c;
        @(negedge clk);
        off_count = CW'(n); rst_count = CW'(r);
        pwr_off_en = 1'b1; pwr_good = tied; sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        check("R2 supply_on", int'(supply_on), 0);
        check("R2 dom_rst", int'(dom_rst), 1);
        rst_count = CW'(r + 7);
        t = 1;
        wake_evt = 1'b1; wake_code = 2'b10;
        @(negedge clk);
        if (!supply_on) t++;
        wake_evt = early; wake_code = 2'b00;
        @(negedge clk);
        if (!supply_on) t++;
        wake_evt = 1'b0;
        if (early) begin
            do begin
                @(negedge clk);
                if (!supply_on) t++;
            end while (!supply_on && t < 2000);
            check("R3 R4 off cycles", t, (n + 1) * P);
        end else begin
            repeat ((n + 1) * P + 2) @(negedge clk);
            check("R5 R6 supply after expiry, no wake", int'(supply_on), 0);
            wake_evt = 1'b1; wake_code = 2'b01;
            @(negedge clk);
            check("R5 wrong code ignored", int'(supply_on), 0);
            wake_code = 2'b00;
            @(negedge clk);
            wake_evt = 1'b0;
            check("R6 accepted wake", int'(supply_on), 1);
        end
        check("R7 busy on restore", int'(seq_busy), 1);
        check("R7 reset held on restore", int'(dom_rst), 1);
        if (tied) begin
            c = 1;
            do begin
                @(negedge clk);
                if (dom_rst) c++;
            end while (dom_rst && c < 2000);
            check("R8 R9 hold cycles (tied)", c, (r + 1) * P + 1);
        end else begin
            repeat (3) @(negedge clk);
            check("R7 reset held, no power-good", int'(dom_rst), 1);
            check("R7 busy, no power-good", int'(seq_busy), 1);
            pwr_good = 1'b1;
            c = 0;
            do begin
                @(negedge clk);
                if (dom_rst) c++;
            end while (dom_rst && c < 2000);
            check("R8 R9 hold cycles", c, (r + 1) * P);
        end
        check("R8 busy cleared", int'(seq_busy), 0);
        check("R11 supply on at release", int'(supply_on), 1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 supply_on", int'(supply_on), 1);
        check("R1 dom_rst", int'(dom_rst), 0);
        check("R1 seq_busy", int'(seq_busy), 0);

        // R10: sleep with power-off disabled
        pwr_off_en = 1'b0; sleep_req = 1'b1; off_count = CW'(2); rst_count = CW'(1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R10 supply stays on", int'(supply_on), 1);
            check("R10 reset stays off", int'(dom_rst), 0);
        end
        sleep_req = 1'b0;

        for (int n = 0; n < 4; n++)
            for (int r = 0; r < 4; r++)
                for (int m = 0; m < 4; m++)
                    run_seq(n, r, m[0], m[1]);

        done = 1'b1;
        finish_run();
    end
endmodule